// File: doc/BRIEF.md
# SRAM Power-Up Dummy-Read Sequencer

This block sits in a controller for synchronous SRAM devices with separate read and write ports. Once the controller's own start-up has finished, the sequencer sends a fixed run of throwaway reads to every attached device, one device after another. Each device has its own active-low read-select line. The data that comes back from these reads is never used. The purpose of the reads is to put each device's output stage back into a known state before real traffic is allowed.

When the devices use a nine-bit data bus, every device gets two passes. In the first pass one chosen address bit is held low, and in the second pass the same bit is held high. An optional wait of a configurable number of clock cycles runs before the first read. This gives the devices' impedance-matching circuits time to settle after a period with a floating clock. When the last read's latency has elapsed, a sticky `ready` flag goes high. Until then, the controller keeps all user reads and writes stalled.

Top module: `sram_wake_seq`

## Requirements
- R1: In the cycle after any clock edge that samples `rst` high, every `rd_sel_n` bit is 1, `ready` is 0 and `addr` is 0.
- R2: No `rd_sel_n` bit goes low before the sequencer in its idle state has sampled `init_done` high.
- R3: The first read-select pulse appears exactly SETTLE_CYC+2 cycles after the cycle in which the idle sequencer first sees `init_done` high. SETTLE_CYC defaults to 1000 and may be 0.
- R4: The pulses are issued one per cycle with no gaps. Each device receives E pulses per pass, where E is READS_PER_DEV raised to 16 if it is set lower.
- R5: At most one `rd_sel_n` bit is low in any cycle. Devices are served strictly in ascending index order, starting at index 0.
- R6: With NARROW=0 the address during a pulse is the pulse's index within its device's run (0 to E-1). `addr` is 0 in cycles without a pulse.
- R7: With NARROW=1 each device gets two passes of E pulses. Address bit SEL_BIT is 0 throughout the first pass and 1 throughout the second. The remaining address bits carry the index within the pass.
- R8: `ready` first goes high exactly RD_LAT cycles after the cycle of the last pulse. It then stays high until reset, and no further pulse is issued.
- R9: Once the sequence has started, changes on `init_done` have no effect: the run continues unchanged, and after `ready` rises it is not repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_done | input | 1 | Controller start-up finished; starts the sequence |
| rd_sel_n | output | NUM_DEV | Per-device active-low read select, registered |
| addr | output | ADDR_W | Dummy-read address, registered |
| ready | output | 1 | High once all dummy reads have drained; releases user traffic |

## Verification
The checker assumes that each run begins from a synchronous reset. Its high-water device index and its armed flag are cleared only by `rst`. It also assumes that `init_done` is a plain level that may drop or pulse at any time after it has been seen. The bench raises `init_done` once per reset, toggles it both in the middle of a run and after `ready`, and starts a new run only by asserting `rst`. The assertions therefore never see a second sequence without a reset in between. Two configurations are exercised: a narrow-bus build with three devices and a 1000-cycle settle, and a wide build with no settle whose low read count is raised to the minimum. Every pulse of both runs is compared with an index computed in the bench.

// File: rtl/sram_wake_pkg.sv
package sram_wake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_ISSUE  = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_DONE   = 3'd4
  } wake_state_e;

  localparam int MIN_READS = 16;

  // Reads per device actually issued: the request, but never below the floor.
  function automatic int eff_reads(input int req);
    return (req < MIN_READS) ? MIN_READS : req;
  endfunction

endpackage

// File: rtl/swk_span_cnt.sv
// Counts cycles while run is high; last marks the LIMIT-th cycle of the span.
module swk_span_cnt #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign last = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/swk_sweep.sv
// Walks read index, pass and device in that nesting order, one step per read.
module swk_sweep #(
  parameter int NUM_DEV = 4,
  parameter int RD_EFF  = 16,
  parameter int NPASS   = 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  step,
  output logic [((NUM_DEV > 1) ? $clog2(NUM_DEV) : 1)-1:0] dev_idx,
  output logic                                  pass_bit,
  output logic [$clog2(RD_EFF)-1:0]             rd_idx,
  output logic                                  last
);
  localparam int DW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int IW = $clog2(RD_EFF);

  logic [DW-1:0] dev_q;
  logic          pass_q;
  logic [IW-1:0] idx_q;
  logic          idx_end;
  logic          pass_end;
  logic          dev_end;

  assign idx_end  = (idx_q == IW'(RD_EFF - 1));
  assign pass_end = (NPASS == 1) || pass_q;
  assign dev_end  = (dev_q == DW'(NUM_DEV - 1));
  assign last     = idx_end && pass_end && dev_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q  <= '0;
      pass_q <= 1'b0;
      idx_q  <= '0;
    end else if (step) begin
      if (idx_end) begin
        idx_q <= '0;
        if (pass_end) begin
          pass_q <= 1'b0;
          dev_q  <= dev_q + 1'b1;
        end else begin
          pass_q <= 1'b1;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign dev_idx  = dev_q;
  assign pass_bit = pass_q;
  assign rd_idx   = idx_q;
endmodule

// File: rtl/swk_strobe_drv.sv
// Output register stage: one active-low select per device plus the address.
module swk_strobe_drv #(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W  = 20,
  parameter int DW      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [DW-1:0]      dev_sel,
  input  logic [ADDR_W-1:0]  addr_in,
  output logic [NUM_DEV-1:0] rd_sel_n,
  output logic [ADDR_W-1:0]  addr
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
    logic sel_n_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_n_q <= 1'b1;
      end else begin
        sel_n_q <= !(fire && (dev_sel == DW'(g)));
      end
    end
    assign rd_sel_n[g] = sel_n_q;
  end

  logic [ADDR_W-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      addr_q <= fire ? addr_in : '0;
    end
  end
  assign addr = addr_q;
endmodule

// File: rtl/sram_wake_seq.sv
module sram_wake_seq
  import sram_wake_pkg::*;
#(
  parameter int NUM_DEV       = 4,
  parameter int READS_PER_DEV = 16,
  parameter int ADDR_W        = 20,
  parameter int NARROW        = 0,
  parameter int SEL_BIT       = 3,
  parameter int SETTLE_CYC    = 1000,
  parameter int RD_LAT        = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_done,
  output logic [NUM_DEV-1:0] rd_sel_n,
  output logic [ADDR_W-1:0]  addr,
  output logic               ready
);
  localparam int RD_EFF  = eff_reads(READS_PER_DEV);
  localparam int NPASS   = (NARROW != 0) ? 2 : 1;
  localparam int DW      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int IW      = $clog2(RD_EFF);
  localparam int DRAIN_N = (RD_LAT < 1) ? 1 : RD_LAT;

  wake_state_e state_q, state_d;
  logic        settle_run, settle_last;
  logic        drain_run, drain_last;
  logic        fire;
  logic [DW-1:0] dev_idx;
  logic        pass_bit;
  logic [IW-1:0] rd_idx;
  logic        sweep_last;
  logic [ADDR_W-1:0] addr_raw;
  logic        ready_q;

  assign settle_run = (state_q == ST_SETTLE);
  assign drain_run  = (state_q == ST_DRAIN);
  assign fire       = (state_q == ST_ISSUE);

  if (SETTLE_CYC > 0) begin : g_settle
    swk_span_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
      .clk  (clk),
      .rst  (rst),
      .run  (settle_run),
      .last (settle_last)
    );
  end else begin : g_no_settle
    assign settle_last = 1'b0;
  end

  swk_span_cnt #(.LIMIT(DRAIN_N)) u_drain (
    .clk  (clk),
    .rst  (rst),
    .run  (drain_run),
    .last (drain_last)
  );

  swk_sweep #(
    .NUM_DEV (NUM_DEV),
    .RD_EFF  (RD_EFF),
    .NPASS   (NPASS)
  ) u_sweep (
    .clk      (clk),
    .rst      (rst),
    .step     (fire),
    .dev_idx  (dev_idx),
    .pass_bit (pass_bit),
    .rd_idx   (rd_idx),
    .last     (sweep_last)
  );

  // Index in the low bits; on narrow-bus devices one bit carries the pass.
  always_comb begin
    addr_raw = ADDR_W'(rd_idx);
    if (NARROW != 0) begin
      addr_raw[SEL_BIT] = pass_bit;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (init_done) state_d = (SETTLE_CYC > 0) ? ST_SETTLE : ST_ISSUE;
      ST_SETTLE: if (settle_last) state_d = ST_ISSUE;
      ST_ISSUE:  if (sweep_last) state_d = ST_DRAIN;
      ST_DRAIN:  if (drain_last) state_d = ST_DONE;
      ST_DONE:   state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_DONE);
    end
  end

  swk_strobe_drv #(
    .NUM_DEV (NUM_DEV),
    .ADDR_W  (ADDR_W),
    .DW      (DW)
  ) u_drv (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .dev_sel  (dev_idx),
    .addr_in  (addr_raw),
    .rd_sel_n (rd_sel_n),
    .addr     (addr)
  );

  assign ready = ready_q;
endmodule

// File: rtl/swk_chk.sv
module swk_chk #(
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               init_done,
  input logic [NUM_DEV-1:0] rd_sel_n,
  input logic               ready
);
  localparam int DW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic          rst_d;
  logic          armed_q;
  logic          seen_q;
  logic [DW-1:0] hi_q;
  logic [DW-1:0] cur_dev;
  logic          any_sel;

  assign any_sel = !(&rd_sel_n);

  always_comb begin
    cur_dev = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (!rd_sel_n[i]) cur_dev = DW'(i);
    end
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      hi_q    <= '0;
    end else begin
      armed_q <= armed_q | init_done;
      if (any_sel) begin
        seen_q <= 1'b1;
        hi_q   <= cur_dev;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_d) begin
      AST_RESET_QUIET: assert (&rd_sel_n && !ready); // R1
    end
  end

  AST_WAIT_FOR_INIT: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> &rd_sel_n); // R2

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones(~rd_sel_n) <= 1); // R5

  AST_ASCENDING_DEV: assert property (@(posedge clk) disable iff (rst)
    (any_sel && seen_q) |-> (cur_dev >= hi_q)); // R5

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R8

  AST_QUIET_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    ready |-> &rd_sel_n); // R8
endmodule

bind sram_wake_seq swk_chk #(.NUM_DEV(NUM_DEV)) u_swk_chk (
  .clk       (clk),
  .rst       (rst),
  .init_done (init_done),
  .rd_sel_n  (rd_sel_n),
  .ready     (ready)
);

// File: tb/tb_sram_wake_seq.sv
// Per-DUT monitor: predicts every pulse arithmetically and checks it.
module swk_mon #(
  parameter int    NUM_DEV = 2,
  parameter int    READS   = 16,
  parameter int    NARROW  = 0,
  parameter int    SEL_BIT = 0,
  parameter int    ADDR_W  = 8,
  parameter int    SETTLE  = 0,
  parameter int    LAT     = 1,
  parameter string TAG     = "a"
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_done,
  input  logic [NUM_DEV-1:0] sel_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               ready,
  output int                 n_chk,
  output int                 n_bad,
  output logic               done
);
  localparam int EFF   = (READS < 16) ? 16 : READS;
  localparam int NP    = (NARROW != 0) ? 2 : 1;
  localparam int TOTAL = NUM_DEV * EFF * NP;

  int cyc = 0;
  int t0 = 0;
  int k = 0;
  int last_cyc = 0;
  bit started = 0;
  bit rdy_seen = 0;

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", TAG, req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int low, dv, ed, ep, ea;
    cyc++;
    if (rst) begin
      started  = 0;
      rdy_seen = 0;
      k        = 0;
    end else begin
      low = 0;
      dv  = 0;
      for (int i = 0; i < NUM_DEV; i++) begin
        if (!sel_n[i]) begin
          low++;
          dv = i;
        end
      end
      if (low > 0) begin
        if (!started) chk(0, "R2", low, 0);
        else if (rdy_seen) chk(0, "R8", low, 0);
        else begin
          chk(low == 1, "R5", low, 1);
          ed = k / (EFF * NP);
          ep = (k / EFF) % NP;
          ea = (k % EFF) & ((1 << ADDR_W) - 1);
          chk(dv == ed, "R5", dv, ed);
          if (NARROW != 0) begin
            ea = (ea & ~(1 << SEL_BIT)) | (ep << SEL_BIT);
            chk(int'(addr) == ea, "R7", int'(addr), ea);
          end else begin
            chk(int'(addr) == ea, "R6", int'(addr), ea);
          end
          if (k == 0) chk(cyc == t0 + SETTLE + 2, "R3", cyc - t0, SETTLE + 2);
          else chk(cyc == last_cyc + 1, "R4", cyc - last_cyc, 1);
          k++;
          last_cyc = cyc;
        end
      end else if (started && k > 0 && !rdy_seen) begin
        chk(addr == '0, "R6", int'(addr), 0);
      end
      if (ready && !rdy_seen) begin
        rdy_seen = 1;
        chk(k == TOTAL, "R4", k, TOTAL);
        chk(cyc == last_cyc + LAT, "R8", cyc - last_cyc, LAT);
      end else if (!ready && rdy_seen) begin
        chk(0, "R8", 0, 1);
      end
      if (!started && init_done) begin
        started = 1;
        t0 = cyc;
      end
    end
    done = rdy_seen;
  end
endmodule

module tb_sram_wake_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_a = 1'b0;
  logic init_b = 1'b0;

  localparam int A_DEV = 3, A_AW = 6;
  localparam int B_DEV = 2, B_AW = 5;

  logic [A_DEV-1:0] sel_a;
  logic [A_AW-1:0]  addr_a;
  logic             ready_a;
  logic [B_DEV-1:0] sel_b;
  logic [B_AW-1:0]  addr_b;
  logic             ready_b;

  int chk_a, bad_a, chk_b, bad_b;
  logic done_a, done_b;
  int top_chk = 0;
  int top_bad = 0;

  always #4 clk = ~clk;

  sram_wake_seq #(
    .NUM_DEV(A_DEV), .READS_PER_DEV(16), .ADDR_W(A_AW), .NARROW(1),
    .SEL_BIT(2), .SETTLE_CYC(1000), .RD_LAT(3)
  ) dut (
    .clk(clk), .rst(rst), .init_done(init_a),
    .rd_sel_n(sel_a), .addr(addr_a), .ready(ready_a)
  );

  sram_wake_seq #(
    .NUM_DEV(B_DEV), .READS_PER_DEV(4), .ADDR_W(B_AW), .NARROW(0),
    .SEL_BIT(0), .SETTLE_CYC(0), .RD_LAT(1)
  ) dut_b (
    .clk(clk), .rst(rst), .init_done(init_b),
    .rd_sel_n(sel_b), .addr(addr_b), .ready(ready_b)
  );

  swk_mon #(.NUM_DEV(A_DEV), .READS(16), .NARROW(1), .SEL_BIT(2), .ADDR_W(A_AW),
            .SETTLE(1000), .LAT(3), .TAG("a")) u_mon_a (
    .clk(clk), .rst(rst), .init_done(init_a), .sel_n(sel_a), .addr(addr_a),
    .ready(ready_a), .n_chk(chk_a), .n_bad(bad_a), .done(done_a)
  );

  swk_mon #(.NUM_DEV(B_DEV), .READS(4), .NARROW(0), .SEL_BIT(0), .ADDR_W(B_AW),
            .SETTLE(0), .LAT(1), .TAG("b")) u_mon_b (
    .clk(clk), .rst(rst), .init_done(init_b), .sel_n(sel_b), .addr(addr_b),
    .ready(ready_b), .n_chk(chk_b), .n_bad(bad_b), .done(done_b)
  );

  task automatic tchk(input bit ok, input string req, input int act, input int exp);
    top_chk++;
    if (!ok) begin
      top_bad++;
      $display("FAIL top %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet_check(input string req, input bit want_ready);
    tchk(&sel_a, req, int'(sel_a), (1 << A_DEV) - 1);
    tchk(&sel_b, req, int'(sel_b), (1 << B_DEV) - 1);
    tchk(ready_a == want_ready, req, int'(ready_a), int'(want_ready));
    tchk(addr_a == '0, req, int'(addr_a), 0);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d",
             top_chk + chk_a + chk_b, top_bad + bad_a + bad_b);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    quiet_check("R1", 1'b0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    quiet_check("R2", 1'b0);
    @(posedge clk); #1 init_a = 1'b1; init_b = 1'b1;
    // R9: drop and re-raise the start level in the middle of run b
    repeat (10) @(posedge clk); #1 init_b = 1'b0;
    repeat (3) @(posedge clk);  #1 init_b = 1'b1;
    while (!done_b) @(posedge clk);
    #1 init_b = 1'b0;
    repeat (2) @(posedge clk); #1 init_b = 1'b1;
    repeat (10) @(negedge clk);
    tchk(ready_b == 1'b1, "R9", int'(ready_b), 1);
    tchk(&sel_b, "R9", int'(sel_b), (1 << B_DEV) - 1);
    while (!done_a) @(posedge clk);
    repeat (5) @(posedge clk);
    #1 init_a = 1'b0; init_b = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    quiet_check("R1", 1'b0);
    tchk(ready_b == 1'b0, "R1", int'(ready_b), 0);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    top_chk++;
    top_bad++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    report();
  end
endmodule